// File: doc/BRIEF.md
# Dependency-Aware Multi-Issue Selector

This block picks operations out of a small window of held micro-operations and sends them to a shared pool of typed execution units. Several can go in the same clock cycle. A slot tag names each window slot. A slot holds one operation: up to two producer tags that it reads, a unit class and a latency. An operation becomes eligible once each producer it reads has finished. The block never sees operand values. It decides when an operation may go only from the latency of each granted producer.

In every cycle the selector walks the window from the oldest slot to the youngest and grants each eligible operation. It stops when either limit runs out: the total issue width, or the unit budget of that operation's class. An operation that is held back is skipped, and younger operations can still be granted past it. A granted operation finishes a fixed number of cycles later. At that point it raises a one-cycle completion pulse and sets its bit in a completion map. The bit stays set until the slot is loaded again. Two running counters, one for cycles and one for granted operations, let the caller work out the issue rate.

Top module: `iss_select`

## Requirements
- R1: In each cycle the number of set bits in `grant` is at most `ISSUE_W`, and `grant_cnt` equals that number.
- R2: An operation is granted only while it is waiting and each source it uses (`*_use`=1) names a slot whose bit is set in `done_map`. A source with its use flag at 0 has no effect.
- R3: Class codes are 0 = ALU, 1 = multiplier, 2 = memory. In one cycle at most `N_ALU`, `N_MUL` and `N_MEM` operations of each class are granted, and all budgets refill every cycle. Class code 3 has no units and is never granted.
- R4: An operation granted in cycle c with latency L, where L = 0 counts as 1, raises `done_pulse[tag]` for exactly cycle c+L. From that cycle on, its bit in `done_map` is set.
- R5: Slot 0 is the oldest and a higher tag is younger. Eligible operations are granted in rising tag order. An operation blocked by its class budget does not stop younger ones. Once the issue width is used up, younger eligible operations wait.
- R6: A load into slot t (`ld_en`=1 at a rising edge) clears `done_map[t]` from the next cycle on. The operation can be granted from the next cycle on, and it is granted exactly once.
- R7: `cycle_total` goes up by one on every clock edge after reset. `issued_total` goes up by `grant_cnt` on every edge.
- R8: Right after reset, every slot is empty, and `grant`, `done_map`, `done_pulse` and both counters are zero.
- R9: Take two independent chains of two single-cycle ALU operations whose heads both become eligible in cycle c. The heads are granted in cycle c and the two dependents in cycle c+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write one operation into a slot at this edge |
| ld_tag | input | TAG_W | Slot being written |
| ld_a_use | input | 1 | First source is used |
| ld_a_tag | input | TAG_W | First producer slot |
| ld_b_use | input | 1 | Second source is used |
| ld_b_tag | input | TAG_W | Second producer slot |
| ld_cls | input | 2 | Unit class code |
| ld_lat | input | LAT_W | Latency in cycles (0 counts as 1) |
| grant | output | WIN | Slots granted in this cycle |
| grant_cnt | output | CW | Number of grants in this cycle |
| done_pulse | output | WIN | Slots whose latency runs out in this cycle |
| done_map | output | WIN | Completion bit of each slot |
| issued_total | output | CNT_W | Running count of granted operations |
| cycle_total | output | CNT_W | Cycles since reset |

## Verification
`grant` and `grant_cnt` are combinational from registered slot state, so they are due in the same cycle as the state that makes an operation eligible. A load takes effect one edge after it is driven. `done_pulse` and `done_map` change L edges after the grant cycle. The two counters reflect a grant one edge after it. The bench drives inputs and samples outputs 2 ns after the falling clock edge. A reference model keyed on the bench's own cycle number predicts every output for that cycle, and the directed cases compare fixed grant patterns at cycle numbers worked out in advance.

// File: rtl/iss_pkg.sv
package iss_pkg;
   typedef enum logic [1:0] {
      CL_ALU  = 2'd0,
      CL_MUL  = 2'd1,
      CL_MEM  = 2'd2,
      CL_NONE = 2'd3
   } op_cls_e;

   typedef enum logic [1:0] {
      ST_EMPTY = 2'd0,
      ST_WAIT  = 2'd1,
      ST_FLY   = 2'd2,
      ST_DONE  = 2'd3
   } slot_st_e;

   function automatic int tag_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/iss_slot_bank.sv
module iss_slot_bank
   import iss_pkg::*;
#(
   parameter int WIN   = 8,
   parameter int LAT_W = 3,
   localparam int TAG_W = tag_bits(WIN),
   localparam int DX    = 1 << TAG_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ld_en,
   input  logic [TAG_W-1:0]            ld_tag,
   input  logic                        ld_a_use,
   input  logic [TAG_W-1:0]            ld_a_tag,
   input  logic                        ld_b_use,
   input  logic [TAG_W-1:0]            ld_b_tag,
   input  logic [1:0]                  ld_cls,
   input  logic [LAT_W-1:0]            ld_lat,
   input  logic [WIN-1:0]              grant,
   output logic [WIN-1:0]              ready,
   output logic [WIN-1:0]              done_map,
   output logic [WIN-1:0]              done_pulse,
   output logic [WIN-1:0][1:0]         cls,
   output logic [WIN-1:0]              a_use,
   output logic [WIN-1:0]              b_use,
   output logic [WIN-1:0][TAG_W-1:0]   a_tag,
   output logic [WIN-1:0][TAG_W-1:0]   b_tag
);
   logic [DX-1:0] done_ext;
   assign done_ext = DX'(done_map);

   for (genvar i = 0; i < WIN; i++) begin : g_slot
      slot_st_e            st_q;
      logic [LAT_W-1:0]    lat_q;
      logic [LAT_W-1:0]    rem_q;
      logic                pulse_q;
      logic                au_q, bu_q;
      logic [TAG_W-1:0]    at_q, bt_q;
      logic [1:0]          cls_q;
      logic                hit;

      assign hit = ld_en && (ld_tag == TAG_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q    <= ST_EMPTY;
            lat_q   <= '0;
            rem_q   <= '0;
            pulse_q <= 1'b0;
            au_q    <= 1'b0;
            bu_q    <= 1'b0;
            at_q    <= '0;
            bt_q    <= '0;
            cls_q   <= CL_NONE;
         end else begin
            pulse_q <= 1'b0;
            if (hit) begin
               st_q  <= ST_WAIT;
               lat_q <= ld_lat;
               rem_q <= '0;
               au_q  <= ld_a_use;
               bu_q  <= ld_b_use;
               at_q  <= ld_a_tag;
               bt_q  <= ld_b_tag;
               cls_q <= ld_cls;
            end else begin
               case (st_q)
                  ST_WAIT: begin
                     if (grant[i]) begin
                        if (lat_q <= LAT_W'(1)) begin
                           st_q    <= ST_DONE;
                           pulse_q <= 1'b1;
                        end else begin
                           st_q  <= ST_FLY;
                           rem_q <= lat_q - LAT_W'(1);
                        end
                     end
                  end
                  ST_FLY: begin
                     if (rem_q == LAT_W'(1)) begin
                        st_q    <= ST_DONE;
                        pulse_q <= 1'b1;
                        rem_q   <= '0;
                     end else begin
                        rem_q <= rem_q - LAT_W'(1);
                     end
                  end
                  default: ;
               endcase
            end
         end
      end

      assign done_map[i]   = (st_q == ST_DONE);
      assign done_pulse[i] = pulse_q;
      assign cls[i]        = cls_q;
      assign a_use[i]      = au_q;
      assign b_use[i]      = bu_q;
      assign a_tag[i]      = at_q;
      assign b_tag[i]      = bt_q;
      assign ready[i]      = (st_q == ST_WAIT)
                           && (!au_q || done_ext[at_q])
                           && (!bu_q || done_ext[bt_q]);
   end
endmodule

// File: rtl/iss_pick.sv
module iss_pick #(
   parameter int WIN     = 8,
   parameter int ISSUE_W = 4,
   parameter int N_ALU   = 2,
   parameter int N_MUL   = 1,
   parameter int N_MEM   = 1,
   localparam int CW     = $clog2(ISSUE_W + 1)
) (
   input  logic [WIN-1:0]      ready,
   input  logic [WIN-1:0][1:0] cls,
   output logic [WIN-1:0]      grant,
   output logic [CW-1:0]       grant_cnt
);
   localparam int BUD [4] = '{N_ALU, N_MUL, N_MEM, 0};
   localparam bit CAPPED  = ISSUE_W < WIN;

   always_comb begin
      int left;
      int n;
      int used [4];
      grant = '0;
      left  = ISSUE_W;
      n     = 0;
      for (int k = 0; k < 4; k++) used[k] = 0;
      for (int i = 0; i < WIN; i++) begin
         if ((!CAPPED || left > 0) && ready[i] && used[cls[i]] < BUD[cls[i]]) begin
            grant[i]      = 1'b1;
            used[cls[i]]  = used[cls[i]] + 1;
            left          = left - 1;
            n             = n + 1;
         end
      end
      grant_cnt = CW'(n);
   end
endmodule

// File: rtl/iss_tally.sv
module iss_tally #(
   parameter int CW    = 3,
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    grant_cnt,
   output logic [CNT_W-1:0] issued_total,
   output logic [CNT_W-1:0] cycle_total
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issued_total <= '0;
         cycle_total  <= '0;
      end else begin
         issued_total <= issued_total + CNT_W'(grant_cnt);
         cycle_total  <= cycle_total + CNT_W'(1);
      end
   end
endmodule

// File: rtl/iss_select.sv
module iss_select
   import iss_pkg::*;
#(
   parameter int WIN     = 8,
   parameter int ISSUE_W = 4,
   parameter int N_ALU   = 2,
   parameter int N_MUL   = 1,
   parameter int N_MEM   = 1,
   parameter int LAT_W   = 3,
   parameter int CNT_W   = 32,
   localparam int TAG_W  = tag_bits(WIN),
   localparam int CW     = $clog2(ISSUE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic              ld_a_use,
   input  logic [TAG_W-1:0]  ld_a_tag,
   input  logic              ld_b_use,
   input  logic [TAG_W-1:0]  ld_b_tag,
   input  logic [1:0]        ld_cls,
   input  logic [LAT_W-1:0]  ld_lat,
   output logic [WIN-1:0]    grant,
   output logic [CW-1:0]     grant_cnt,
   output logic [WIN-1:0]    done_pulse,
   output logic [WIN-1:0]    done_map,
   output logic [CNT_W-1:0]  issued_total,
   output logic [CNT_W-1:0]  cycle_total
);
   if (WIN < 2 || ISSUE_W < 1 || LAT_W < 1 || CNT_W < CW
       || N_ALU < 0 || N_MUL < 0 || N_MEM < 0) begin : g_bad_cfg
      initial $fatal(1, "iss_select: illegal parameter set");
   end

   logic [WIN-1:0]            ready;
   logic [WIN-1:0][1:0]       cls;
   logic [WIN-1:0]            a_use, b_use;
   logic [WIN-1:0][TAG_W-1:0] a_tag, b_tag;

   iss_slot_bank #(.WIN(WIN), .LAT_W(LAT_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_en      (ld_en),
      .ld_tag     (ld_tag),
      .ld_a_use   (ld_a_use),
      .ld_a_tag   (ld_a_tag),
      .ld_b_use   (ld_b_use),
      .ld_b_tag   (ld_b_tag),
      .ld_cls     (ld_cls),
      .ld_lat     (ld_lat),
      .grant      (grant),
      .ready      (ready),
      .done_map   (done_map),
      .done_pulse (done_pulse),
      .cls        (cls),
      .a_use      (a_use),
      .b_use      (b_use),
      .a_tag      (a_tag),
      .b_tag      (b_tag)
   );

   iss_pick #(
      .WIN(WIN), .ISSUE_W(ISSUE_W),
      .N_ALU(N_ALU), .N_MUL(N_MUL), .N_MEM(N_MEM)
   ) u_pick (
      .ready     (ready),
      .cls       (cls),
      .grant     (grant),
      .grant_cnt (grant_cnt)
   );

   iss_tally #(.CW(CW), .CNT_W(CNT_W)) u_tally (
      .clk          (clk),
      .rst_n        (rst_n),
      .grant_cnt    (grant_cnt),
      .issued_total (issued_total),
      .cycle_total  (cycle_total)
   );
endmodule

// File: rtl/iss_select_chk.sv
module iss_select_chk #(
   parameter int WIN     = 8,
   parameter int ISSUE_W = 4,
   parameter int N_ALU   = 2,
   parameter int N_MUL   = 1,
   parameter int N_MEM   = 1,
   parameter int CNT_W   = 32,
   parameter int TAG_W   = 3,
   parameter int CW      = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ld_en,
   input logic [TAG_W-1:0]          ld_tag,
   input logic [WIN-1:0]            grant,
   input logic [CW-1:0]             grant_cnt,
   input logic [WIN-1:0]            done_pulse,
   input logic [WIN-1:0]            done_map,
   input logic [CNT_W-1:0]          issued_total,
   input logic [CNT_W-1:0]          cycle_total,
   input logic [WIN-1:0][1:0]       cls,
   input logic [WIN-1:0]            a_use,
   input logic [WIN-1:0]            b_use,
   input logic [WIN-1:0][TAG_W-1:0] a_tag,
   input logic [WIN-1:0][TAG_W-1:0] b_tag
);
   localparam int DX = 1 << TAG_W;
   logic [DX-1:0]  done_ext;
   logic [WIN-1:0] m_alu, m_mul, m_mem, m_none;
   assign done_ext = DX'(done_map);

   for (genvar i = 0; i < WIN; i++) begin : g_cls
      assign m_alu[i]  = cls[i] == 2'd0;
      assign m_mul[i]  = cls[i] == 2'd1;
      assign m_mem[i]  = cls[i] == 2'd2;
      assign m_none[i] = cls[i] == 2'd3;
   end

   a_r1_width: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant) <= ISSUE_W);
   a_r1_count: assert property (@(posedge clk) disable iff (!rst_n)
      int'(grant_cnt) == $countones(grant));
   a_r3_alu: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant & m_alu) <= N_ALU);
   a_r3_mul: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant & m_mul) <= N_MUL);
   a_r3_mem: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant & m_mem) <= N_MEM);
   a_r3_none: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & m_none) == '0);
   a_r7_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> cycle_total == $past(cycle_total) + CNT_W'(1));
   a_r7_issued: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> issued_total == $past(issued_total) + CNT_W'($past(grant_cnt)));

   for (genvar i = 0; i < WIN; i++) begin : g_slot_chk
      a_r2_src_a: assert property (@(posedge clk) disable iff (!rst_n)
         (grant[i] && a_use[i]) |-> done_ext[a_tag[i]]);
      a_r2_src_b: assert property (@(posedge clk) disable iff (!rst_n)
         (grant[i] && b_use[i]) |-> done_ext[b_tag[i]]);
      a_r4_pulse_rise: assert property (@(posedge clk) disable iff (!rst_n)
         done_pulse[i] |-> (done_map[i] && !$past(done_map[i])));
      a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
         (grant[i] && !(ld_en && ld_tag == TAG_W'(i))) |=> !grant[i]);
      a_r6_reload_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_en && ld_tag == TAG_W'(i)) |=> !done_map[i]);
   end
endmodule

bind iss_select iss_select_chk #(
   .WIN(WIN), .ISSUE_W(ISSUE_W), .N_ALU(N_ALU), .N_MUL(N_MUL), .N_MEM(N_MEM),
   .CNT_W(CNT_W), .TAG_W(TAG_W), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_tag(ld_tag),
   .grant(grant), .grant_cnt(grant_cnt), .done_pulse(done_pulse),
   .done_map(done_map), .issued_total(issued_total), .cycle_total(cycle_total),
   .cls(cls), .a_use(a_use), .b_use(b_use), .a_tag(a_tag), .b_tag(b_tag)
);

// File: tb/test_iss_select.sv
module test_iss_select;
   localparam int WIN   = 8;
   localparam int IW    = 3;
   localparam int NA    = 2;
   localparam int NM    = 1;
   localparam int NE    = 1;
   localparam int LAT_W = 3;
   localparam int CNT_W = 32;
   localparam int TAG_W = 3;
   localparam int CW    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_en = 1'b0;
   logic [TAG_W-1:0] ld_tag = '0, ld_a_tag = '0, ld_b_tag = '0;
   logic ld_a_use = 1'b0, ld_b_use = 1'b0;
   logic [1:0] ld_cls = '0;
   logic [LAT_W-1:0] ld_lat = '0;
   logic [WIN-1:0] grant, done_pulse, done_map;
   logic [CW-1:0] grant_cnt;
   logic [CNT_W-1:0] issued_total, cycle_total;

   always #10 clk = ~clk;

   iss_select #(
      .WIN(WIN), .ISSUE_W(IW), .N_ALU(NA), .N_MUL(NM), .N_MEM(NE),
      .LAT_W(LAT_W), .CNT_W(CNT_W)
   ) i_iss_select (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_tag(ld_tag),
      .ld_a_use(ld_a_use), .ld_a_tag(ld_a_tag), .ld_b_use(ld_b_use),
      .ld_b_tag(ld_b_tag), .ld_cls(ld_cls), .ld_lat(ld_lat),
      .grant(grant), .grant_cnt(grant_cnt), .done_pulse(done_pulse),
      .done_map(done_map), .issued_total(issued_total), .cycle_total(cycle_total)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // reference model: 0 empty, 1 waiting, 2 granted
   int     m_st [WIN];
   bit     m_au [WIN], m_bu [WIN];
   int     m_a [WIN], m_b [WIN], m_c [WIN], m_l [WIN];
   longint m_cd [WIN];
   longint cyc = 0;
   longint m_issued = 0;

   function automatic bit m_done(int t);
      return m_st[t] == 2 && m_cd[t] <= cyc;
   endfunction

   function automatic int budget(int c);
      case (c)
         0: return NA;
         1: return NM;
         2: return NE;
         default: return 0;
      endcase
   endfunction

   function automatic logic [WIN-1:0] m_grant();
      logic [WIN-1:0] g = '0;
      int left = IW;
      int used [4] = '{0, 0, 0, 0};
      for (int i = 0; i < WIN; i++) begin
         if (left > 0 && m_st[i] == 1 && (!m_au[i] || m_done(m_a[i]))
             && (!m_bu[i] || m_done(m_b[i])) && used[m_c[i]] < budget(m_c[i])) begin
            g[i] = 1'b1;
            used[m_c[i]]++;
            left--;
         end
      end
      return g;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // called shortly after a falling edge; compares, then drives the next edge
   task automatic step(bit ld, int t, bit au, int a, bit bu, int b, int c, int l);
      logic [WIN-1:0] eg, ep, em;
      #2;
      eg = m_grant();
      ep = '0;
      em = '0;
      for (int i = 0; i < WIN; i++) begin
         ep[i] = m_st[i] == 2 && m_cd[i] == cyc;
         em[i] = m_done(i);
      end
      chk(grant == eg, "R2 R3 R5 R6 grant", grant, eg);
      chk(int'(grant_cnt) == $countones(eg), "R1 grant_cnt", grant_cnt, $countones(eg));
      chk($countones(grant) <= IW, "R1 width", $countones(grant), IW);
      chk(done_pulse == ep, "R4 done_pulse", done_pulse, ep);
      chk(done_map == em, "R4 done_map", done_map, em);
      chk(cycle_total == CNT_W'(cyc), "R7 cycle_total", cycle_total, cyc);
      chk(issued_total == CNT_W'(m_issued), "R7 issued_total", issued_total, m_issued);
      for (int i = 0; i < WIN; i++) begin
         if (eg[i]) begin
            m_st[i] = 2;
            m_cd[i] = cyc + ((m_l[i] < 1) ? 1 : m_l[i]);
         end
      end
      m_issued += $countones(eg);
      if (ld) begin
         m_st[t] = 1; m_au[t] = au; m_a[t] = a; m_bu[t] = bu; m_b[t] = b;
         m_c[t] = c; m_l[t] = l;
      end
      ld_en = ld; ld_tag = TAG_W'(t); ld_a_use = au; ld_a_tag = TAG_W'(a);
      ld_b_use = bu; ld_b_tag = TAG_W'(b); ld_cls = 2'(c); ld_lat = LAT_W'(l);
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic expect_grant(logic [WIN-1:0] exp, string req);
      #1;
      chk(grant == exp, req, grant, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int t, a, b, c, l;
      bit au, bu;
      for (int i = 0; i < WIN; i++) begin
         m_st[i] = 0; m_au[i] = 0; m_bu[i] = 0; m_a[i] = 0; m_b[i] = 0;
         m_c[i] = 0; m_l[i] = 0; m_cd[i] = 0;
      end
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
      #1;
      // R8 reset state
      chk(grant == '0, "R8 grant", grant, 0);
      chk(done_map == '0, "R8 done_map", done_map, 0);
      chk(done_pulse == '0, "R8 done_pulse", done_pulse, 0);
      chk(cycle_total == '0 && issued_total == '0, "R8 counters", cycle_total, 0);

      // R9: two chains gated by a memory op in slot 4 (latency 4)
      step(1, 4, 0, 0, 0, 0, 2, 4);
      step(1, 0, 1, 4, 0, 0, 0, 1);
      step(1, 1, 1, 0, 0, 0, 1, 3);
      step(1, 2, 1, 4, 0, 0, 0, 1);
      step(1, 3, 1, 2, 0, 0, 0, 1);
      expect_grant(8'h05, "R9 chain heads");
      step(0, 0, 0, 0, 0, 0, 0, 0);
      expect_grant(8'h0A, "R9 chain dependents");
      idle(5);
      chk(done_map[1] == 1'b1, "R4 multiply done", done_map[1], 1);

      // R3 R5: six ops released together by gate in slot 7 (latency 7)
      step(1, 7, 0, 0, 0, 0, 2, 7);
      step(1, 0, 1, 7, 0, 0, 0, 1);
      step(1, 1, 0, 0, 1, 7, 0, 2);
      step(1, 2, 1, 7, 0, 0, 0, 1);
      step(1, 3, 1, 7, 1, 7, 2, 1);
      step(1, 4, 1, 7, 0, 0, 1, 3);
      step(1, 5, 1, 7, 0, 0, 0, 0);
      expect_grant(8'h00, "R2 gate pending");
      step(0, 0, 0, 0, 0, 0, 0, 0);
      expect_grant(8'h0B, "R3 R5 alu budget and width");
      step(0, 0, 0, 0, 0, 0, 0, 0);
      expect_grant(8'h34, "R5 leftovers");
      idle(6);

      // constrained random traffic
      for (int n = 0; n < 500; n++) begin
         t = -1;
         if ($urandom_range(9) < 7) begin
            int s = $urandom_range(WIN - 1);
            for (int k = 0; k < WIN; k++) begin
               int q = (s + k) % WIN;
               if (t < 0 && (m_st[q] == 0 || m_done(q))) t = q;
            end
         end
         if (t >= 0) begin
            a = $urandom_range(WIN - 1);
            b = $urandom_range(WIN - 1);
            au = $urandom_range(1) == 1 && a != t && m_st[a] != 1;
            bu = $urandom_range(1) == 1 && b != t && m_st[b] != 1;
            c = $urandom_range(2);
            l = ($urandom_range(7) == 0) ? 7 : $urandom_range(4);
            step(1, t, au, a, bu, b, c, l);
         end else begin
            step(0, 0, 0, 0, 0, 0, 0, 0);
         end
      end
      idle(12);

      // R3: class code 3 never issues
      t = -1;
      for (int k = 0; k < WIN; k++) if (t < 0 && (m_st[k] == 0 || m_done(k))) t = k;
      if (t >= 0) begin
         step(1, t, 0, 0, 0, 0, 3, 1);
         idle(5);
         #1;
         chk(grant[t] == 1'b0 && done_map[t] == 1'b0, "R3 class 3 held",
             {grant[t], done_map[t]}, 0);
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule